// File: doc/BRIEF.md
# Speculative Global History Updater

This block holds the fetch-side global branch history that a direction predictor uses when it sees more than one branch in a fetch group. On each accepted fetch it takes the number of valid branch slots in the group and the predicted direction of the last of them, and it forms the next speculative history. The earlier branches in the group enter as not-taken bits and the final direction enters at bit 0. When execute reports a misprediction, the speculative history is replaced with the architectural history that execute supplies.

The shift depends on the branch count: no shift, one place, two places, three places, or four places for four or more branches. For groups of three or more branches, a parameter picks one of two policies. With the default policy the older upper bits stay where they are and are not pushed out, because a long run of correct predictions is unlikely and recovery repairs the history anyway. The other policy is a plain full shift.

Top module: `spec_ghr_update`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `hist` is all zeros.
- R2: An accepted fetch (`fetch_vld`=1, `mispredict`=0) with `br_count`=0 leaves `hist` unchanged.
- R3: An accepted fetch with `br_count`=1 makes `hist` equal to {old `hist`[W-2:0], `final_dir`}.
- R4: An accepted fetch with `br_count`=2 makes `hist` equal to {old `hist`[W-3:0], 0, `final_dir`}. Bit 1 is 0 and bit 0 is the final direction.
- R5: With `KEEP_UPPER`=1, an accepted fetch with `br_count`=3 leaves bits [W-1:3] at their old values, clears bits 2 and 1, and puts `final_dir` in bit 0.
- R6: With `KEEP_UPPER`=1, an accepted fetch with `br_count` from 4 to 15 leaves bits [W-1:4] at their old values, clears bits 3 to 1, and puts `final_dir` in bit 0.
- R7: With `KEEP_UPPER`=0, an accepted fetch with `br_count`=3 gives {old `hist` shifted left by 3, zeros below, `final_dir` in bit 0}. A count of 4 or more does the same with a shift of 4.
- R8: `mispredict`=1 loads `arch_hist` into `hist` on the next edge, whatever `fetch_vld` and `br_count` are doing in that cycle.
- R9: When `fetch_vld`=0 and `mispredict`=0, `hist` holds its value whatever `br_count` and `final_dir` are.
- R10: With `HIST_W`=2, any count from 2 to 15 gives {0, `final_dir`} under either policy. Every count fills bit positions that exist; nothing outside the width is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_vld | input | 1 | Fetch group accepted this cycle |
| br_count | input | 4 | Valid branch slots in the group |
| final_dir | input | 1 | Predicted direction of the last branch (1 = taken) |
| mispredict | input | 1 | Execute reports a misprediction |
| arch_hist | input | HIST_W | Architectural history from execute |
| hist | output | HIST_W | Speculative global history |

## Verification
Every result appears one clock edge after its stimulus, because the only storage is the history register. A fetch update, a recovery load or a hold is visible in `hist` after the rising edge that samples the inputs. The bench drives inputs on the falling edge and compares `hist` at the next falling edge against its own bit-by-bit model. It runs three instances: wide with the keep policy, wide with the full shift, and a 2-bit instance with the keep policy. Each check therefore has exactly one cycle of latency to account for and never samples near an active edge.

// File: rtl/spec_ghr_update.sv
module spec_ghr_update #(
  parameter int HIST_W     = 8,
  parameter bit KEEP_UPPER = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_vld,
  input  logic [3:0]        br_count,
  input  logic              final_dir,
  input  logic              mispredict,
  input  logic [HIST_W-1:0] arch_hist,
  output logic [HIST_W-1:0] hist
);
  localparam int EW = HIST_W + 4;

  logic [HIST_W-1:0] hist_q, merged, shifted, kept;
  logic [2:0]        shamt;
  logic [EW-1:0]     ext_sh, lo_mask;

  assign shamt   = (br_count >= 4'd4) ? 3'd4 : br_count[2:0];
  assign ext_sh  = {4'b0000, hist_q} << shamt;
  assign lo_mask = ({{(EW-1){1'b0}}, 1'b1} << shamt) - {{(EW-1){1'b0}}, 1'b1};
  assign shifted = ext_sh[HIST_W-1:0] | {{(HIST_W-1){1'b0}}, final_dir};
  assign kept    = (hist_q & ~lo_mask[HIST_W-1:0]) | {{(HIST_W-1){1'b0}}, final_dir};

  generate
    if (KEEP_UPPER) begin : g_keep
      assign merged = (shamt == 3'd0) ? hist_q :
                      (shamt >= 3'd3) ? kept : shifted;
    end else begin : g_full
      assign merged = (shamt == 3'd0) ? hist_q : shifted;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)          hist_q <= '0;
    else if (mispredict) hist_q <= arch_hist;
    else if (fetch_vld)  hist_q <= merged;
  end

  assign hist = hist_q;
endmodule

// File: rtl/spec_ghr_update_chk.sv
module spec_ghr_update_chk #(
  parameter int HIST_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_vld,
  input logic [3:0]        br_count,
  input logic              final_dir,
  input logic              mispredict,
  input logic [HIST_W-1:0] arch_hist,
  input logic [HIST_W-1:0] hist
);
  logic accept;
  assign accept = fetch_vld && !mispredict;

  a_r1_reset_clear: assert property (@(posedge clk) !rst_n |=> hist == '0);

  a_r2_zero_hold: assert property (@(posedge clk) disable iff (!rst_n)
    accept && br_count == 4'd0 |=> $stable(hist));

  a_r3_one_shift: assert property (@(posedge clk) disable iff (!rst_n)
    accept && br_count == 4'd1 |=> hist == {$past(hist[HIST_W-2:0]), $past(final_dir)});

  a_r4_two_low: assert property (@(posedge clk) disable iff (!rst_n)
    accept && br_count == 4'd2 |=> hist[1] == 1'b0 && hist[0] == $past(final_dir));

  a_r5_final_bit: assert property (@(posedge clk) disable iff (!rst_n)
    accept && br_count >= 4'd3 |=> hist[0] == $past(final_dir) && hist[1] == 1'b0);

  a_r8_recover: assert property (@(posedge clk) disable iff (!rst_n)
    mispredict |=> hist == $past(arch_hist));

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_vld && !mispredict |=> $stable(hist));
endmodule

bind spec_ghr_update spec_ghr_update_chk #(.HIST_W(HIST_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_vld(fetch_vld), .br_count(br_count),
  .final_dir(final_dir), .mispredict(mispredict), .arch_hist(arch_hist),
  .hist(hist)
);

// File: tb/spec_ghr_update_tb.sv
module spec_ghr_update_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fetch_vld = 1'b0;
  logic [3:0] br_count = 4'd0;
  logic       final_dir = 1'b0;
  logic       mispredict = 1'b0;
  logic [7:0] arch_hist = 8'h00;
  logic [7:0] hist_k, hist_f;
  logic [1:0] hist_n;
  logic [7:0] exp_k, exp_f;
  logic [1:0] exp_n;
  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  spec_ghr_update #(.HIST_W(8), .KEEP_UPPER(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .fetch_vld(fetch_vld), .br_count(br_count),
    .final_dir(final_dir), .mispredict(mispredict), .arch_hist(arch_hist),
    .hist(hist_k));
  spec_ghr_update #(.HIST_W(8), .KEEP_UPPER(1'b0)) u_full (
    .clk(clk), .rst_n(rst_n), .fetch_vld(fetch_vld), .br_count(br_count),
    .final_dir(final_dir), .mispredict(mispredict), .arch_hist(arch_hist),
    .hist(hist_f));
  spec_ghr_update #(.HIST_W(2), .KEEP_UPPER(1'b1)) u_narrow (
    .clk(clk), .rst_n(rst_n), .fetch_vld(fetch_vld), .br_count(br_count),
    .final_dir(final_dir), .mispredict(mispredict), .arch_hist(arch_hist[1:0]),
    .hist(hist_n));

  function automatic logic [7:0] model(input logic [7:0] h, input int cnt,
                                       input logic fin, input bit keep, input int w);
    logic [7:0] r;
    int s;
    s = (cnt >= 4) ? 4 : cnt;
    if (s == 0) return h;
    r = '0;
    for (int i = 0; i < w; i++) begin
      if (i == 0)                r[i] = fin;
      else if (i < s)            r[i] = 1'b0;
      else if (keep && s >= 3)   r[i] = h[i];
      else                       r[i] = h[i-s];
    end
    return r;
  endfunction

  task automatic compare(input string tag);
    tests++;
    if (hist_k !== exp_k) begin
      fails++;
      $display("FAIL %s keep8: got %h expected %h", tag, hist_k, exp_k);
    end
    tests++;
    if (hist_f !== exp_f) begin
      fails++;
      $display("FAIL %s full8: got %h expected %h", tag, hist_f, exp_f);
    end
    tests++;
    if (hist_n !== exp_n) begin
      fails++;
      $display("FAIL %s narrow2: got %b expected %b", tag, hist_n, exp_n);
    end
  endtask

  task automatic step(input string tag, input logic vld, input int cnt,
                      input logic fin, input logic mp, input logic [7:0] arch);
    @(negedge clk);
    fetch_vld = vld; br_count = cnt[3:0]; final_dir = fin;
    mispredict = mp; arch_hist = arch;
    if (mp) begin
      exp_k = arch; exp_f = arch; exp_n = arch[1:0];
    end else if (vld) begin
      exp_k = model(exp_k, cnt, fin, 1'b1, 8);
      exp_f = model(exp_f, cnt, fin, 1'b0, 8);
      exp_n = model({6'b0, exp_n}, cnt, fin, 1'b1, 2) >> 0;
    end
    @(negedge clk);
    compare(tag);
    fetch_vld = 1'b0; mispredict = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    exp_k = '0; exp_f = '0; exp_n = '0;
    compare("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after release");
  endtask

  task automatic t_recover;
    step("R8 load", 1'b0, 0, 1'b0, 1'b1, 8'hA7);
    step("R8 priority over fetch", 1'b1, 2, 1'b1, 1'b1, 8'h5E);
  endtask

  task automatic t_counts;
    step("R8 seed", 1'b0, 0, 1'b0, 1'b1, 8'hB5);
    step("R2 zero count", 1'b1, 0, 1'b1, 1'b0, 8'h00);
    step("R3 one taken", 1'b1, 1, 1'b1, 1'b0, 8'h00);
    step("R3 one not taken", 1'b1, 1, 1'b0, 1'b0, 8'h00);
    step("R4 two taken", 1'b1, 2, 1'b1, 1'b0, 8'h00);
    step("R8 reseed", 1'b0, 0, 1'b0, 1'b1, 8'hFF);
    step("R5 R7 three taken", 1'b1, 3, 1'b1, 1'b0, 8'h00);
    step("R8 reseed", 1'b0, 0, 1'b0, 1'b1, 8'hEE);
    step("R5 R7 three not taken", 1'b1, 3, 1'b0, 1'b0, 8'h00);
    for (int c = 4; c < 16; c++) begin
      step("R8 reseed", 1'b0, 0, 1'b0, 1'b1, 8'hF3 ^ c[7:0]);
      step("R6 R7 R10 four plus", 1'b1, c, c[0], 1'b0, 8'h00);
    end
  endtask

  task automatic t_idle;
    step("R8 reseed", 1'b0, 0, 1'b0, 1'b1, 8'h6D);
    step("R9 idle count3", 1'b0, 3, 1'b1, 1'b0, 8'h00);
    step("R9 idle count1", 1'b0, 1, 1'b0, 1'b0, 8'hFF);
  endtask

  task automatic t_narrow;
    step("R8 narrow seed", 1'b0, 0, 1'b0, 1'b1, 8'h03);
    step("R10 narrow count2", 1'b1, 2, 1'b1, 1'b0, 8'h00);
    step("R8 narrow seed", 1'b0, 0, 1'b0, 1'b1, 8'h03);
    step("R10 narrow count3", 1'b1, 3, 1'b0, 1'b0, 8'h00);
    step("R8 narrow seed", 1'b0, 0, 1'b0, 1'b1, 8'h02);
    step("R10 narrow count4", 1'b1, 4, 1'b1, 1'b0, 8'h00);
  endtask

  task automatic t_mixed;
    for (int i = 0; i < 40; i++)
      step("R2 R3 R4 R5 R6 mixed", 1'b1, (i * 7) % 16, i[1] ^ i[0], 1'b0, 8'h00);
  endtask

  initial begin
    t_reset();
    t_recover();
    t_counts();
    t_idle();
    t_narrow();
    t_mixed();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule